// File: doc/BRIEF.md
# Conditional Execution Prefix Gate

This block sits beside the retire stage of a small processor pipeline. When a conditional-execution prefix instruction is issued, the block tests a 4-bit condition selector against the four status flags (N, Z, C, V) once, at that moment. It then controls which of the instructions after the prefix may take effect. Two run lengths come with the prefix: a "taken" run and an "untaken" run. The taken run is counted first.

If the condition holds, the instructions of the taken run execute and the instructions of the untaken run are suppressed. If the condition fails, the taken run is suppressed and the untaken run executes. Each retire strobe uses up one slot of whichever run is still open. When both runs are used up, the enable output stays high until another prefix arrives. The enable output describes the instruction that is retiring now. The logic downstream uses it to block that instruction's register and flag writes.

The run lengths and the outcome are captured at the prefix, so later changes on the flags or count inputs have no effect. A prefix that arrives during an open window discards that window and starts a new one.

Top module: `cond_exec_gate`

## Requirements
- R1: While reset is asserted, and afterwards until the first prefix, exec_enable is 1 and both runs are empty, so a retire strobe leaves exec_enable at 1.
- R2: Selector codes 0 to 7 test one flag each: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear.
- R3: Code 8 holds when C is set and Z is clear. Code 9 holds when C is clear or Z is set.
- R4: Signed codes: 10 holds when N equals V, 11 when N differs from V, 12 when Z is clear and N equals V, 13 when Z is set or N differs from V.
- R5: Code 14 always holds and code 15 never holds, whatever the flags.
- R6: After a prefix whose condition holds, exec_enable is 1 for the next taken-count retires and 0 for the untaken-count retires that follow.
- R7: After a prefix whose condition fails, exec_enable is 0 for the next taken-count retires and 1 for the untaken-count retires that follow.
- R8: The two counts and the outcome are captured in the cycle the prefix strobe is high. Later changes on the count, selector or flag inputs do not alter the window.
- R9: Once both runs are used up, exec_enable is 1 and further retires leave it at 1.
- R10: A prefix during an open window replaces the remaining counts and the outcome with the new prefix's values.
- R11: A retire strobe in the same cycle as a prefix strobe uses up no slot. The window starts with the full counts of that prefix.
- R12: A prefix with both counts zero leaves exec_enable at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_valid | input | 1 | Conditional prefix issued this cycle |
| pfx_cond | input | 4 | Condition selector |
| pfx_taken_len | input | CNT_W | Length of the first (taken) run |
| pfx_untaken_len | input | CNT_W | Length of the second (untaken) run |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| retire | input | 1 | One instruction retires this cycle |
| exec_enable | output | 1 | The retiring instruction may take effect |

## Verification
A prefix strobe and a retire strobe can occur in the same cycle, so the load of new counts and the decrement of an open run can fall on the same clock edge. The random stimulus raises both strobes independently, so these collisions happen often, both inside open windows and outside them. Directed cases also place a colliding prefix in the middle of a window. The bench model gives the prefix priority and drops the retire. After the collision it checks that the full taken and untaken runs play out retire by retire.

// File: rtl/cxp_pkg.sv
package cxp_pkg;

  typedef enum logic [3:0] {
    CC_ZS  = 4'd0,  CC_ZC  = 4'd1,  CC_CS  = 4'd2,  CC_CC  = 4'd3,
    CC_NS  = 4'd4,  CC_NC  = 4'd5,  CC_VS  = 4'd6,  CC_VC  = 4'd7,
    CC_UHI = 4'd8,  CC_ULS = 4'd9,  CC_SGE = 4'd10, CC_SLT = 4'd11,
    CC_SGT = 4'd12, CC_SLE = 4'd13, CC_ALW = 4'd14, CC_NEV = 4'd15
  } cond_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Evaluate one condition selector against a flag set.
  function automatic logic cond_holds(input cond_sel_e sel, input flags_t f);
    logic r;
    case (sel)
      CC_ZS:   r = f.z;
      CC_ZC:   r = !f.z;
      CC_CS:   r = f.c;
      CC_CC:   r = !f.c;
      CC_NS:   r = f.n;
      CC_NC:   r = !f.n;
      CC_VS:   r = f.v;
      CC_VC:   r = !f.v;
      CC_UHI:  r = f.c && !f.z;
      CC_ULS:  r = !f.c || f.z;
      CC_SGE:  r = (f.n == f.v);
      CC_SLT:  r = (f.n != f.v);
      CC_SGT:  r = !f.z && (f.n == f.v);
      CC_SLE:  r = f.z || (f.n != f.v);
      CC_ALW:  r = 1'b1;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cxp_cond_eval.sv
module cxp_cond_eval
  import cxp_pkg::*;
(
  input  logic [3:0] sel,
  input  logic       fn,
  input  logic       fz,
  input  logic       fc,
  input  logic       fv,
  output logic       hit
);
  flags_t fl;

  always_comb begin
    fl  = '{n: fn, z: fz, c: fc, v: fv};
    hit = cond_holds(cond_sel_e'(sel), fl);
  end
endmodule

// File: rtl/cxp_run_counter.sv
module cxp_run_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             empty
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (dec && !empty) cnt_q <= cnt_q - 1'b1;
  end

  assign count = cnt_q;
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/cond_exec_gate.sv
module cond_exec_gate #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pfx_valid,
  input  logic [3:0]       pfx_cond,
  input  logic [CNT_W-1:0] pfx_taken_len,
  input  logic [CNT_W-1:0] pfx_untaken_len,
  input  logic             flag_n,
  input  logic             flag_z,
  input  logic             flag_c,
  input  logic             flag_v,
  input  logic             retire,
  output logic             exec_enable
);
  localparam int NUM_RUNS = 2;

  // Named internal events, used by the checker
  logic             cond_now;
  logic             cond_hold;
  logic             taken_empty;
  logic             untaken_empty;
  logic [CNT_W-1:0] taken_left;
  logic [CNT_W-1:0] untaken_left;
  logic             win_idle;
  logic             slot_use;
  logic             dec_taken;
  logic             dec_untaken;

  logic [CNT_W-1:0] run_load_val [NUM_RUNS];
  logic [CNT_W-1:0] run_count    [NUM_RUNS];
  logic             run_empty    [NUM_RUNS];
  logic             run_dec      [NUM_RUNS];

  cxp_cond_eval u_eval (
    .sel (pfx_cond),
    .fn  (flag_n),
    .fz  (flag_z),
    .fc  (flag_c),
    .fv  (flag_v),
    .hit (cond_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         cond_hold <= 1'b1;
    else if (pfx_valid) cond_hold <= cond_now;
  end

  // A prefix has priority: a retire in the same cycle uses no slot.
  assign slot_use    = retire && !pfx_valid;
  assign dec_taken   = slot_use && !taken_empty;
  assign dec_untaken = slot_use && taken_empty && !untaken_empty;

  assign run_load_val[0] = pfx_taken_len;
  assign run_load_val[1] = pfx_untaken_len;
  assign run_dec[0]      = dec_taken;
  assign run_dec[1]      = dec_untaken;

  for (genvar gi = 0; gi < NUM_RUNS; gi++) begin : g_run
    cxp_run_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pfx_valid),
      .load_val (run_load_val[gi]),
      .dec      (run_dec[gi]),
      .count    (run_count[gi]),
      .empty    (run_empty[gi])
    );
  end

  assign taken_left    = run_count[0];
  assign untaken_left  = run_count[1];
  assign taken_empty   = run_empty[0];
  assign untaken_empty = run_empty[1];
  assign win_idle      = taken_empty && untaken_empty;

  always_comb begin
    if (!taken_empty)        exec_enable = cond_hold;
    else if (!untaken_empty) exec_enable = !cond_hold;
    else                     exec_enable = 1'b1;
  end
endmodule

// File: rtl/cond_exec_gate_chk.sv
module cond_exec_gate_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pfx_valid,
  input logic [3:0]       pfx_cond,
  input logic [CNT_W-1:0] pfx_taken_len,
  input logic [CNT_W-1:0] pfx_untaken_len,
  input logic             retire,
  input logic             exec_enable,
  input logic             cond_hold,
  input logic [CNT_W-1:0] taken_left,
  input logic [CNT_W-1:0] untaken_left,
  input logic             win_idle
);
  // R9
  idle_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_idle |-> exec_enable);

  // R9
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_idle && !pfx_valid) |=> win_idle);

  // R6
  taken_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_left != '0) |-> (exec_enable == cond_hold));

  // R7
  untaken_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_left == '0 && untaken_left != '0) |-> (exec_enable != cond_hold));

  // R11
  prefix_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_valid |=> (taken_left == $past(pfx_taken_len) && untaken_left == $past(pfx_untaken_len)));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pfx_valid |=> $stable(cond_hold));

  // R5
  always_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_valid && pfx_cond == 4'd14) |=> cond_hold);

  // R5
  never_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_valid && pfx_cond == 4'd15) |=> !cond_hold);

  // R6
  taken_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !pfx_valid && taken_left != '0) |=> (taken_left == $past(taken_left) - 1'b1));
endmodule

bind cond_exec_gate cond_exec_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .pfx_valid       (pfx_valid),
  .pfx_cond        (pfx_cond),
  .pfx_taken_len   (pfx_taken_len),
  .pfx_untaken_len (pfx_untaken_len),
  .retire          (retire),
  .exec_enable     (exec_enable),
  .cond_hold       (cond_hold),
  .taken_left      (taken_left),
  .untaken_left    (untaken_left),
  .win_idle        (win_idle)
);

// File: tb/cond_exec_gate_test.sv
module cond_exec_gate_test;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pfx_valid = 1'b0;
  logic [3:0]       pfx_cond = '0;
  logic [CNT_W-1:0] pfx_taken_len = '0;
  logic [CNT_W-1:0] pfx_untaken_len = '0;
  logic             flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
  logic             retire = 1'b0;
  logic             exec_enable;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Bench model
  int    m_t = 0;
  int    m_f = 0;
  bit    m_ok = 1'b1;
  string m_tag = "R1";

  always #4 clk = ~clk;

  cond_exec_gate #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .pfx_valid(pfx_valid), .pfx_cond(pfx_cond),
    .pfx_taken_len(pfx_taken_len), .pfx_untaken_len(pfx_untaken_len),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .retire(retire), .exec_enable(exec_enable)
  );

  // Conditions come in complementary pairs: the odd code inverts the even one.
  function automatic bit ref_cond(input logic [3:0] c, input bit n, input bit z,
                                  input bit cy, input bit v);
    bit base;
    case (c[3:1])
      3'd0: base = z;
      3'd1: base = cy;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = cy & ~z;
      3'd5: base = ~(n ^ v);
      3'd6: base = ~z & ~(n ^ v);
      default: base = 1'b1;
    endcase
    return base ^ c[0];
  endfunction

  function automatic string code_tag(input logic [3:0] c);
    if (c < 8)       return "R2";
    else if (c < 10) return "R3";
    else if (c < 14) return "R4";
    return "R5";
  endfunction

  function automatic bit exp_en();
    if (m_t > 0) return m_ok;
    if (m_f > 0) return !m_ok;
    return 1'b1;
  endfunction

  task automatic check_now();
    bit e;
    e = exp_en();
    n_vec++;
    if (exec_enable !== e) begin
      n_bad++;
      $display("FAIL %s: exec_enable actual=%0b expected=%0b (time %0t)", m_tag, exec_enable, e, $time);
    end
  endtask

  // Check the present output, then drive one cycle of stimulus and advance the model.
  task automatic step(input bit p, input logic [3:0] c, input int t, input int f,
                      input bit n, input bit z, input bit cy, input bit v,
                      input bit r, input string tag);
    @(negedge clk);
    check_now();
    pfx_valid = p; pfx_cond = c;
    pfx_taken_len = CNT_W'(t); pfx_untaken_len = CNT_W'(f);
    flag_n = n; flag_z = z; flag_c = cy; flag_v = v; retire = r;
    if (!rst_n) begin
      m_t = 0; m_f = 0; m_ok = 1'b1;
    end else if (p) begin
      m_ok = ref_cond(c, n, z, cy, v); m_t = t; m_f = f;
    end else if (r) begin
      if (m_t > 0) m_t--;
      else if (m_f > 0) m_f--;
    end
    m_tag = tag;
  endtask

  task automatic idle(input int k, input string tag);
    for (int i = 0; i < k; i++) step(0, 4'd0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic rets(input int k, input string tag);
    for (int i = 0; i < k; i++) step(0, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, 1, tag);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    // R1: reset state, retire under and after reset has no effect
    step(0, 4'd0, 0, 0, 0, 0, 0, 0, 1, "R1");
    step(0, 4'd0, 0, 0, 0, 0, 0, 0, 1, "R1");
    @(negedge clk); rst_n = 1'b1;
    rets(3, "R1");
    idle(1, "R1");

    // R2..R5: every selector against every flag set, taken run of one
    for (int c = 0; c < 16; c++) begin
      for (int fl = 0; fl < 16; fl++) begin
        step(1, 4'(c), 1, 0, fl[3], fl[2], fl[1], fl[0], 0, code_tag(4'(c)));
        step(0, 4'd0, 0, 0, 0, 0, 0, 0, 1, code_tag(4'(c)));
      end
    end
    idle(1, "R9");

    // R6: true outcome, 3 enabled then 2 suppressed, then idle
    step(1, 4'd14, 3, 2, 0, 0, 0, 0, 0, "R6");
    rets(5, "R6");
    rets(2, "R9");
    // R7: false outcome
    step(1, 4'd15, 2, 3, 0, 0, 0, 0, 0, "R7");
    rets(5, "R7");
    idle(1, "R9");
    // R8: inputs change after prefix, no retire; window must hold
    step(1, 4'd0, 2, 2, 0, 1, 0, 0, 0, "R8");
    for (int i = 0; i < 4; i++)
      step(0, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, 0, "R8");
    rets(4, "R8");
    // R10: restart mid window
    step(1, 4'd14, 4, 4, 0, 0, 0, 0, 0, "R10");
    rets(2, "R10");
    step(1, 4'd15, 1, 2, 0, 0, 0, 0, 0, "R10");
    rets(3, "R10");
    // R11: prefix with retire in the same cycle
    step(1, 4'd14, 2, 1, 0, 0, 0, 0, 0, "R11");
    rets(1, "R11");
    step(1, 4'd15, 2, 1, 0, 0, 0, 0, 1, "R11");
    rets(3, "R11");
    // R12: zero counts
    step(1, 4'd15, 0, 0, 0, 0, 0, 0, 1, "R12");
    rets(2, "R12");
    idle(1, "R12");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      bit p;
      logic [3:0] c;
      string tg;
      p = ($urandom_range(0, 7) == 0);
      c = 4'($urandom);
      if (m_t > 0) tg = m_ok ? "R6" : "R7";
      else if (m_f > 0) tg = m_ok ? "R6" : "R7";
      else tg = "R9";
      if (p) tg = code_tag(c);
      step(p, c, $urandom_range(0, 6), $urandom_range(0, 6),
           $urandom, $urandom, $urandom, $urandom, $urandom_range(0, 1), tg);
    end
    idle(2, "R9");

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule